// File: doc/BRIEF.md
# Reciprocal square-root seed unit

This block turns one IEEE-754 single-precision operand into a coarse estimate of 1/sqrt(x). The estimate is meant as the starting point for a later iterative refinement stage. It produces no refined or rounded result of its own. An operand is offered with a one-cycle strobe. The estimate appears on the output one clock later, together with its own strobe and a flag that reports an invalid operation.

For a normal, positive operand, the exponent is computed arithmetically from the biased exponent. The 8 leading significand bits come from a 128-entry constant table. The table index joins the parity of (biased exponent - 1) with the six leading fraction bits. NaNs, zeros, denormals, negative values and infinity bypass the table and receive fixed encodings.

Top module: `rsqrt_seed`

## Requirements
- R1: `outValid` is high in the cycle after a cycle in which `inValid` was high, and low in the cycle after a cycle in which `inValid` was low.
- R2: For a normal positive operand, let d = biased exponent - 1. The table index is {d[0], operand[22:17]}. Result bits 22:15 hold table entry `t[index]` and bits 14:0 are zero. Entries come in pairs: `t[2k]` is an odd value and `t[2k+1]` = `t[2k]` - 1. The sequence starts 253, 252, 245, 244 and ends 3, 2, and never increases along the index.
- R3: For a normal positive operand, result bits 30:23 equal 189 - floor(d/2). Result bit 31 copies the operand sign. The invalid flag is low.
- R4: Any NaN operand (exponent all ones, fraction nonzero) gives 0x7FC00000. The invalid flag is high only when fraction bit 22 is 0, which marks a signaling NaN.
- R5: A zero or denormal operand (exponent field 0) gives infinity with the operand's sign: 0x7F800000 or 0xFF800000. The invalid flag is low.
- R6: A negative operand that is neither NaN, zero nor denormal gives 0x7FC00004 and raises the invalid flag. This includes negative infinity.
- R7: Positive infinity (0x7F800000) gives 0x00000000 with the invalid flag low.
- R8: While `rstN` is low, `outValid`, `outResult` and `outInvalid` are all zero, regardless of the inputs.
- R9: In the cycle after a cycle with `inValid` low, `outResult` and `outInvalid` keep their previous values, whatever `inOperand` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand strobe |
| inOperand | input | 32 | Single-precision operand |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| outResult | output | 32 | Seed estimate or fixed special encoding |
| outInvalid | output | 1 | Invalid-operation flag for the result |

## Verification
A sweep drives all 128 table indices. Each sweep operand gets its own exponent drawn from across the normal range and its own pattern in fraction bits 16:0. This separates three errors: the index taking the wrong exponent bit, low fraction bits leaking into the result, and an exponent formula that is off by one at odd d.

A list of special operands covers the classification priority:
- positive and negative NaNs, to tell quiet from signaling;
- zeros and denormals of both signs;
- negative normal numbers and negative infinity;
- positive infinity;
- the smallest and largest normal values.

Directed tests then check the reset values and confirm that the result and flag hold while no strobe is present.

// File: rtl/rsqrt_seed_pkg.sv
package rsqrt_seed_pkg;
  localparam int WORD_W     = 32;
  localparam int EXP_W      = 8;
  localparam int FRAC_W     = 23;
  localparam int SEED_W     = 8;
  localparam int IDX_FRAC_W = 6;
  localparam int IDX_W      = IDX_FRAC_W + 1;
  localparam int PAIRS      = 1 << IDX_FRAC_W;
  localparam int LOW_ZERO_W = FRAC_W - SEED_W;

  localparam logic [EXP_W-1:0]  EXP_TOP      = 8'd189;
  localparam logic [WORD_W-1:0] QNAN_WORD    = 32'h7FC0_0000;
  localparam logic [WORD_W-1:0] SQRTNAN_WORD = 32'h7FC0_0004;
  localparam logic [WORD_W-2:0] INF_MAG      = 31'h7F80_0000;

  typedef enum logic [2:0] {
    SEL_SEED,
    SEL_QNAN,
    SEL_INF,
    SEL_SQRTNAN,
    SEL_ZERO
  } selE;

  typedef struct packed {
    logic load;
    selE  sel;
    logic flagInv;
  } ctrlS;
endpackage

// File: rtl/rsqrt_seed_ctrl.sv
module rsqrt_seed_ctrl
  import rsqrt_seed_pkg::*;
(
  input  logic              inValid,
  input  logic [WORD_W-1:0] operand,
  output ctrlS              ctrl
);
  logic [EXP_W-1:0]  expF;
  logic [FRAC_W-1:0] fracF;
  logic              neg;
  logic              expMax;
  logic              isNan;
  logic              isSnan;
  logic              isInf;
  logic              isZeroDen;

  assign neg       = operand[WORD_W-1];
  assign expF      = operand[WORD_W-2:FRAC_W];
  assign fracF     = operand[FRAC_W-1:0];
  assign expMax    = &expF;
  assign isNan     = expMax && (|fracF);
  assign isSnan    = isNan && !fracF[FRAC_W-1];
  assign isInf     = expMax && !(|fracF);
  assign isZeroDen = (expF == '0);

  always_comb begin
    ctrl.load    = inValid;
    ctrl.flagInv = isSnan || (!isNan && !isZeroDen && neg);
    if (isNan)          ctrl.sel = SEL_QNAN;
    else if (isZeroDen) ctrl.sel = SEL_INF;
    else if (neg)       ctrl.sel = SEL_SQRTNAN;
    else if (isInf)     ctrl.sel = SEL_ZERO;
    else                ctrl.sel = SEL_SEED;
  end
endmodule

// File: rtl/rsqrt_seed_dp.sv
module rsqrt_seed_dp
  import rsqrt_seed_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlS                  ctrl,
  input  logic                  signIn,
  input  logic [EXP_W-1:0]      expIn,
  input  logic [IDX_FRAC_W-1:0] fracTop,
  output logic                  validQ,
  output logic [WORD_W-1:0]     resultQ,
  output logic                  invalidQ
);
  // Each table pair is {2h+1, 2h}; only h is stored, the even/odd entry
  // is rebuilt from the low index bit.
  localparam logic [SEED_W-2:0] HALF_TAB [PAIRS] = '{
    7'd126, 7'd122, 7'd119, 7'd115, 7'd112, 7'd108, 7'd105, 7'd102,
    7'd100, 7'd97,  7'd94,  7'd92,  7'd89,  7'd87,  7'd84,  7'd82,
    7'd80,  7'd78,  7'd76,  7'd74,  7'd72,  7'd70,  7'd68,  7'd66,
    7'd65,  7'd63,  7'd61,  7'd60,  7'd58,  7'd57,  7'd55,  7'd54,
    7'd51,  7'd49,  7'd46,  7'd44,  7'd41,  7'd39,  7'd37,  7'd35,
    7'd33,  7'd31,  7'd29,  7'd27,  7'd26,  7'd24,  7'd22,  7'd21,
    7'd19,  7'd18,  7'd16,  7'd15,  7'd13,  7'd12,  7'd11,  7'd9,
    7'd8,   7'd7,   7'd6,   7'd5,   7'd4,   7'd3,   7'd2,   7'd1
  };

  logic [EXP_W-1:0]  expM1;
  logic [IDX_W-1:0]  tabIdx;
  logic [SEED_W-1:0] seedSig;
  logic [EXP_W-1:0]  seedExp;
  logic [WORD_W-1:0] seedWord;
  logic [WORD_W-1:0] nextWord;

  assign expM1    = expIn - 1'b1;
  assign tabIdx   = {expM1[0], fracTop};
  assign seedSig  = {HALF_TAB[tabIdx[IDX_W-1:1]], ~tabIdx[0]};
  assign seedExp  = EXP_TOP - {1'b0, expM1[EXP_W-1:1]};
  assign seedWord = {signIn, seedExp, seedSig, {LOW_ZERO_W{1'b0}}};

  always_comb begin
    case (ctrl.sel)
      SEL_QNAN:    nextWord = QNAN_WORD;
      SEL_INF:     nextWord = {signIn, INF_MAG};
      SEL_SQRTNAN: nextWord = SQRTNAN_WORD;
      SEL_ZERO:    nextWord = '0;
      default:     nextWord = seedWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      resultQ  <= '0;
      invalidQ <= 1'b0;
    end else begin
      validQ <= ctrl.load;
      if (ctrl.load) begin
        resultQ  <= nextWord;
        invalidQ <= ctrl.flagInv;
      end
    end
  end
endmodule

// File: rtl/rsqrt_seed.sv
module rsqrt_seed
  import rsqrt_seed_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inOperand,
  output logic              outValid,
  output logic [WORD_W-1:0] outResult,
  output logic              outInvalid
);
  ctrlS ctrl;

  rsqrt_seed_ctrl u_ctrl (
    .inValid (inValid),
    .operand (inOperand),
    .ctrl    (ctrl)
  );

  rsqrt_seed_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .signIn   (inOperand[WORD_W-1]),
    .expIn    (inOperand[WORD_W-2:FRAC_W]),
    .fracTop  (inOperand[FRAC_W-1:FRAC_W-IDX_FRAC_W]),
    .validQ   (outValid),
    .resultQ  (outResult),
    .invalidQ (outInvalid)
  );
endmodule

// File: rtl/rsqrt_seed_chk.sv
module rsqrt_seed_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] inOperand,
  input logic        outValid,
  input logic [31:0] outResult,
  input logic        outInvalid
);
  logic opNan;
  assign opNan = (&inOperand[30:23]) && (|inOperand[22:0]);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_drops_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outResult[30:23] != 8'hFF && outResult[30:23] != 8'h00)
      |-> (outResult[14:0] == 15'd0));
  p_nan_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opNan) |=> (outResult == 32'h7FC0_0000));
  p_zero_to_inf_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOperand[30:23] == 8'h00)
      |=> (outResult[30:0] == 31'h7F80_0000 && outResult[31] == $past(inOperand[31])
           && !outInvalid));
  p_neg_invalid_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOperand[31] && inOperand[30:23] != 8'h00 && !opNan)
      |=> (outInvalid && outResult == 32'h7FC0_0004));
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outResult) && $stable(outInvalid)));
endmodule

bind rsqrt_seed rsqrt_seed_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inOperand  (inOperand),
  .outValid   (outValid),
  .outResult  (outResult),
  .outInvalid (outInvalid)
);

// File: tb/tb_rsqrt_seed.sv
`timescale 1ns/1ps
module tb_rsqrt_seed;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [31:0] inOperand;
  logic        outValid;
  logic [31:0] outResult;
  logic        outInvalid;

  int nChecks = 0;
  int nBad    = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  rsqrt_seed dut (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inOperand  (inOperand),
    .outValid   (outValid),
    .outResult  (outResult),
    .outInvalid (outInvalid)
  );

  // Odd member of each table pair (entry 2k); entry 2k+1 is one less.
  localparam int ODD_TAB [64] = '{
    253, 245, 239, 231, 225, 217, 211, 205,
    201, 195, 189, 185, 179, 175, 169, 165,
    161, 157, 153, 149, 145, 141, 137, 133,
    131, 127, 123, 121, 117, 115, 111, 109,
    103,  99,  93,  89,  83,  79,  75,  71,
     67,  63,  59,  55,  53,  49,  45,  43,
     39,  37,  33,  31,  27,  25,  23,  19,
     17,  15,  13,  11,   9,   7,   5,   3
  };

  // {operand, expected result, expected invalid}
  localparam logic [64:0] VEC [13] = '{
    {32'h7FC0_0000, 32'h7FC0_0000, 1'b0},
    {32'hFFC1_2345, 32'h7FC0_0000, 1'b0},
    {32'h7F80_0001, 32'h7FC0_0000, 1'b1},
    {32'h0000_0000, 32'h7F80_0000, 1'b0},
    {32'h8000_0000, 32'hFF80_0000, 1'b0},
    {32'h0000_0001, 32'h7F80_0000, 1'b0},
    {32'h807F_FFFF, 32'hFF80_0000, 1'b0},
    {32'hBF80_0000, 32'h7FC0_0004, 1'b1},
    {32'hFF80_0000, 32'h7FC0_0004, 1'b1},
    {32'h7F80_0000, 32'h0000_0000, 1'b0},
    {32'h3F80_0000, 32'h3F7E_8000, 1'b0},
    {32'h7F7F_FFFF, 32'h1F81_0000, 1'b0},
    {32'h0080_0000, 32'h5EFE_8000, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] op);
    inValid   = 1'b1;
    inOperand = op;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    rstN      = 1'b0;
    inValid   = 1'b1;
    inOperand = 32'h3F80_0000;
    repeat (3) @(negedge clk);
    // R8: reset holds all outputs at zero despite a strobe
    chk("R8 valid", {31'd0, outValid}, 32'd0);
    chk("R8 result", outResult, 32'd0);
    chk("R8 invalid", {31'd0, outInvalid}, 32'd0);
    inValid = 1'b0;
    rstN    = 1'b1;
    @(negedge clk);
    chk("R1 idle valid", {31'd0, outValid}, 32'd0);

    // special and edge operands: R4 R5 R6 R7, plus R2 R3 extremes
    for (int n = 0; n < 13; n++) begin
      issue(VEC[n][64:33]);
      chk("R1 valid", {31'd0, outValid}, 32'd1);
      chk("R4 R5 R6 R7 R3 result", outResult, VEC[n][32:1]);
      chk("R4 R6 invalid", {31'd0, outInvalid}, {31'd0, VEC[n][0]});
    end

    // table sweep over every index, both exponent parities: R2 R3
    for (int i = 0; i < 128; i++) begin
      int k;
      logic [31:0] op;
      logic [31:0] exp;
      k   = (i * 37) % 127;
      op  = {1'b0, 8'(1 + (i / 64) + 2 * k), 6'(i % 64), 17'(i * 2749 + 5)};
      exp = {1'b0, 8'(189 - k), 8'(ODD_TAB[i / 2] - (i % 2)), 15'd0};
      issue(op);
      chk("R2 R3 sweep result", outResult, exp);
      chk("R3 sweep invalid", {31'd0, outInvalid}, 32'd0);
    end

    // R9: outputs hold while no strobe is present
    issue(32'h7FA0_0000);
    chk("R4 snan result", outResult, 32'h7FC0_0000);
    chk("R4 snan invalid", {31'd0, outInvalid}, 32'd1);
    inValid   = 1'b0;
    inOperand = 32'h3F80_0000;
    @(negedge clk);
    chk("R1 drop valid", {31'd0, outValid}, 32'd0);
    @(negedge clk);
    chk("R9 held result", outResult, 32'h7FC0_0000);
    chk("R9 held invalid", {31'd0, outInvalid}, 32'd1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule